// File: doc/BRIEF.md
# Rate-Dependent Channel Interleaving Packer

This block sits between a fast sample capture stage and the encoder that writes 16-bit storage words. One sample of the channel inputs is taken on every clock. A mode input sets how many channels each sample keeps. In full-width mode all 16 channels go into a word, one sample per word. In dual mode, two successive 8-channel samples share a word. In quad mode, four successive 4-channel samples share a word. This lets the store run at a half or a quarter of the sample rate, at the cost of fewer channels.

Within a shared word, the bits of the samples are interleaved. Each channel's bits from successive samples sit next to each other, and the samples are not laid out as contiguous fields. A one-cycle valid strobe marks each completed word, so the strobe rate is the clock rate divided by the samples per word. After a mode change, the packer starts a fresh word at once.

Top module: `rate_interleave_packer`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and word_o is 0.
- R2: In full-width mode (mode_i = 0), the clock edge that samples chan_i makes word_o equal chan_i and raises valid_o. The word is visible one cycle after the sample.
- R3: In dual mode (mode_i = 1), word bit 2*ch+k holds channel ch (0..7) of sample k. Sample k=0 is the older of the two.
- R4: In quad mode (mode_i = 2), word bit 4*ch+k holds channel ch (0..3) of sample k. Sample k=0 is the oldest of the four.
- R5: valid_o is a one-cycle pulse, one per completed word. In a steady mode it fires every 1, 2 or 4 cycles. It rises the cycle after the sample that completes the word.
- R6: Channels 8..15 have no effect in dual mode. Channels 4..15 have no effect in quad mode.
- R7: When mode_i differs from its value in the previous cycle, the sample taken in that cycle is sample 0 of a new word. A partly filled word is dropped without a strobe.
- R8: word_o keeps its last value in every cycle where valid_o is low.
- R9: Mode code 3 behaves exactly like full-width mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 0 full-width, 1 dual, 2 quad, 3 same as 0 |
| chan_i | input | 16 | Channel levels, sampled every clock |
| word_o | output | 16 | Packed storage word |
| valid_o | output | 1 | One-cycle strobe per completed word |

## Verification
The hardest case is a mode change that lands part-way through a word, especially a change from quad to dual after two or three samples. There, the dropped partial word and the restarted count must both be correct. Random stimulus changes mode with a low probability on any cycle, so it hits every phase offset. Directed sequences force the change at known phases, including a change back to full-width. In dual and quad mode, the unused upper channels get random values, so any leak into the word shows up in the comparison.

// File: rtl/packer_pkg.sv
package packer_pkg;
  typedef enum logic [1:0] {
    MODE_FULL = 2'd0,
    MODE_DUAL = 2'd1,
    MODE_QUAD = 2'd2,
    MODE_RSVD = 2'd3
  } pack_mode_e;

  // samples per storage word for a mode
  function automatic logic [2:0] mode_depth(input logic [1:0] m);
    case (m)
      MODE_DUAL: mode_depth = 3'd2;
      MODE_QUAD: mode_depth = 3'd4;
      default:   mode_depth = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/packer_phase.sv
module packer_phase
  import packer_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  output logic [PH_W-1:0] slot_o,
  output logic            last_o
);
  logic [1:0]      mode_q;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_eff;
  logic [2:0]      depth;

  always_comb begin
    depth     = mode_depth(mode_i);
    phase_eff = (mode_i != mode_q) ? '0 : phase_q;
    last_o    = (phase_eff == PH_W'(depth - 3'd1));
    slot_o    = phase_eff;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_FULL;
      phase_q <= '0;
    end else begin
      mode_q  <= mode_i;
      phase_q <= last_o ? '0 : phase_eff + PH_W'(1);
    end
  end
endmodule

// File: rtl/packer_hold.sv
module packer_hold #(
  parameter int HOLD_W = 8,
  parameter int HOLD_D = 3,
  parameter int PH_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [PH_W-1:0]               slot_i,
  input  logic [HOLD_W-1:0]             din_i,
  output logic [HOLD_D-1:0][HOLD_W-1:0] hold_o
);
  logic [HOLD_D-1:0][HOLD_W-1:0] hold_q;

  for (genvar i = 0; i < HOLD_D; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q[i] <= '0;
      else if (wr_i && slot_i == PH_W'(i)) hold_q[i] <= din_i;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/packer_mux.sv
module packer_mux
  import packer_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int HOLD_W = 8,
  parameter int HOLD_D = 3
) (
  input  logic [1:0]                    mode_i,
  input  logic [WORD_W-1:0]             chan_i,
  input  logic [HOLD_D-1:0][HOLD_W-1:0] hold_i,
  output logic [WORD_W-1:0]             word_o
);
  logic [WORD_W-1:0] dual_w, quad_w;

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam int K2 = b % 2, C2 = b / 2;
    localparam int K4 = b % 4, C4 = b / 4;
    // newest sample comes straight from the input
    if (K2 == 1) begin : g_d_new
      assign dual_w[b] = chan_i[C2];
    end else begin : g_d_old
      assign dual_w[b] = hold_i[K2][C2];
    end
    if (K4 == 3) begin : g_q_new
      assign quad_w[b] = chan_i[C4];
    end else begin : g_q_old
      assign quad_w[b] = hold_i[K4][C4];
    end
  end

  always_comb begin
    case (mode_i)
      MODE_DUAL: word_o = dual_w;
      MODE_QUAD: word_o = quad_w;
      default:   word_o = chan_i;
    endcase
  end
endmodule

// File: rtl/rate_interleave_packer.sv
module rate_interleave_packer
  import packer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] chan_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int MAX_N  = 4;
  localparam int HOLD_W = WORD_W / 2;
  localparam int HOLD_D = MAX_N - 1;
  localparam int PH_W   = $clog2(MAX_N);

  logic [PH_W-1:0]               slot;
  logic                          last;
  logic [HOLD_D-1:0][HOLD_W-1:0] hold;
  logic [WORD_W-1:0]             word_nxt;
  logic [WORD_W-1:0]             word_q;
  logic                          valid_q;

  packer_phase #(.PH_W(PH_W)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .slot_o (slot),
    .last_o (last)
  );

  packer_hold #(.HOLD_W(HOLD_W), .HOLD_D(HOLD_D), .PH_W(PH_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (!last),
    .slot_i (slot),
    .din_i  (chan_i[HOLD_W-1:0]),
    .hold_o (hold)
  );

  packer_mux #(.WORD_W(WORD_W), .HOLD_W(HOLD_W), .HOLD_D(HOLD_D)) u_mux (
    .mode_i (mode_i),
    .chan_i (chan_i),
    .hold_i (hold),
    .word_o (word_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last;
      if (last) word_q <= word_nxt;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/packer_checker.sv
module packer_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [WORD_W-1:0] chan_i,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o
);
  p_full_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |=> valid_o);

  p_full_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |=> word_o == $past(chan_i));

  p_dual_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_i == 2'd1 && $past(mode_i) == 2'd1) |=> !valid_o);

  p_quad_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_i == 2'd2 && $past(mode_i) == 2'd2) |=> !valid_o);

  p_word_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  p_mode_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i) && (mode_i == 2'd1 || mode_i == 2'd2)) |=> !valid_o);
endmodule

bind rate_interleave_packer packer_checker #(.WORD_W(WORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode_i  (mode_i),
  .chan_i  (chan_i),
  .word_o  (word_o),
  .valid_o (valid_o)
);

// File: tb/rate_interleave_packer_tb_top.sv
module rate_interleave_packer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [W-1:0] chan_i = '0;
  logic [W-1:0] word_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string cur_tag = "R2";

  // reference state
  logic [1:0]   bm_mode = 2'd0;
  int           bm_ph = 0;
  logic [W-1:0] bm_hist [4];
  logic [W-1:0] exp_word = '0;
  logic         exp_valid = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rate_interleave_packer #(.WORD_W(W)) dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .chan_i  (chan_i),
    .word_o  (word_o),
    .valid_o (valid_o)
  );

  function automatic int depth_of(input logic [1:0] m);
    return (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
  endfunction

  // bit ch*n+k carries channel ch of sample k (k=0 oldest)
  function automatic logic [W-1:0] pack_ref(input int n, input logic [W-1:0] cur);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) begin
      int k, ch;
      k  = b % n;
      ch = b / n;
      r[b] = (k == n - 1) ? cur[ch] : bm_hist[k][ch];
    end
    return r;
  endfunction

  task automatic model_step(input logic [1:0] m, input logic [W-1:0] c);
    int n, ph;
    n  = depth_of(m);
    ph = (m != bm_mode) ? 0 : bm_ph;
    if (ph == n - 1) begin
      exp_word  = pack_ref(n, c);
      exp_valid = 1'b1;
      bm_ph     = 0;
    end else begin
      bm_hist[ph] = c;
      exp_valid   = 1'b0;
      bm_ph       = ph + 1;
    end
    bm_mode = m;
  endtask

  task automatic check(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic [W-1:0] c);
    mode_i = m;
    chan_i = c;
    @(posedge clk_i);
    model_step(m, c);
    @(negedge clk_i);
    check("R5", "valid", {15'd0, valid_o}, {15'd0, exp_valid});
    check(cur_tag, "word", word_o, exp_word);
  endtask

  initial begin
    int seed;
    logic [1:0] m;
    seed = 32'd20517;
    void'($urandom(seed));
    for (int i = 0; i < 4; i++) bm_hist[i] = '0;

    // R1: reset state
    mode_i = 2'd2;
    chan_i = 16'hFFFF;
    repeat (3) @(negedge clk_i);
    check("R1", "reset valid", {15'd0, valid_o}, 16'd0);
    check("R1", "reset word", word_o, 16'd0);
    rst_ni = 1'b1;

    // R2: full-width passthrough
    cur_tag = "R2";
    step(2'd0, 16'hA5C3);
    step(2'd0, 16'h0001);
    step(2'd0, 16'h8000);

    // R3: dual interleave, k=0 oldest
    cur_tag = "R3";
    step(2'd1, 16'h00FF);
    step(2'd1, 16'h0000);   // expect 16'h5555
    step(2'd1, 16'h0000);
    step(2'd1, 16'h00FF);   // expect 16'hAAAA

    // R4: quad interleave
    cur_tag = "R4";
    step(2'd2, 16'h000F);
    step(2'd2, 16'h0000);
    step(2'd2, 16'h0000);
    step(2'd2, 16'h0000);   // expect 16'h1111
    step(2'd2, 16'h0001);
    step(2'd2, 16'h0002);
    step(2'd2, 16'h0004);
    step(2'd2, 16'h0008);

    // R6: upper channels toggled in dual and quad, low bits fixed
    cur_tag = "R6";
    for (int i = 0; i < 8; i++) step(2'd1, {8'($urandom), 8'h3C});
    for (int i = 0; i < 8; i++) step(2'd2, {12'($urandom), 4'h9});

    // R7: mode change part-way through a word
    cur_tag = "R7";
    step(2'd2, 16'h0005);
    step(2'd2, 16'h000A);
    step(2'd1, 16'h0011);   // partial quad word dropped
    step(2'd1, 16'h0022);
    step(2'd2, 16'h0003);
    step(2'd2, 16'h0006);
    step(2'd2, 16'h000C);
    step(2'd0, 16'hBEEF);   // restart in full-width
    step(2'd1, 16'h00AA);
    step(2'd2, 16'h0007);

    // R9: reserved code acts as full-width
    cur_tag = "R9";
    step(2'd3, 16'h1234);
    step(2'd3, 16'hFEDC);
    step(2'd1, 16'h0033);
    step(2'd3, 16'h5A5A);

    // R8 and mixed: random data, sparse random mode changes
    cur_tag = "R2/R3/R4/R8";
    m = 2'd1;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 15) == 0) m = 2'($urandom_range(0, 3));
      step(m, 16'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule